// File: doc/BRIEF.md
# Read-Path Fault Injecting SEC-DED Checker

This block sits between a memory array and its error-correction logic. Each read returns a 72-bit code word made of 64 data bits and 8 check bits. When the fault-injection controls select a read-side mode and the read address equals the programmed fault address, the block flips one or two chosen bits of the raw word. It then recomputes the check bits over the data half of the possibly corrupted word and forms the syndrome.

A fixed odd-weight column code defines the check bits. A zero syndrome means a clean word. A syndrome equal to one data column, or to a single-bit pattern, is a single error at a known bit. Any other nonzero syndrome is an uncorrectable double error. All results appear one clock after the read. Data correction, write-side injection and register access sit elsewhere.

Top module: `rdinj_sec_ded_chk`

## Requirements
- R1: The word holds data in bits [63:0] and check bits in [71:64]. `stored_chk_o` carries bits [71:64] of the word after injection. `calc_chk_o[j]` is the XOR of every data bit i whose code column has bit j set.
- R2: The outputs are registered. `out_valid_o` is high exactly in the cycle after a cycle with `rd_valid_i` high, and that cycle's results are presented with it. After reset every output is 0.
- R3: Injection happens only when `flt_en_i`=1, `flt_mode_i` is 4 or 5, and `rd_addr_i` equals `flt_addr_i`. With any other mode value (0-3, 6, 7), with the enable low, or with a different address, the word passes through unmodified.
- R4: Mode 4 flips the word bit at `inj_pos0_i`. Mode 5 also flips the bit at `inj_pos1_i`. Equal positions flip that one bit only once. A position of 72 or above flips nothing.
- R5: `syndrome_o` = `stored_chk_o` XOR `calc_chk_o`. A zero syndrome gives `sec_err_o`=0, `ded_err_o`=0 and `bit_idx_o`=0.
- R6: A syndrome equal to the code column of data bit i gives `sec_err_o`=1, `ded_err_o`=0 and `bit_idx_o`=i. The columns include D0=0x23, D1=0x43, D3=0x3D, D10=0x07, D19=0xF4, D35=0xD3, D59=0x9E and D63=0xA4.
- R7: A syndrome of 1<<k (k = 0 to 7) gives `sec_err_o`=1, `ded_err_o`=0 and `bit_idx_o`=64+k.
- R8: Any other nonzero syndrome gives `ded_err_o`=1, `sec_err_o`=0 and `bit_idx_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_valid_i | input | 1 | Read word present this cycle |
| rd_addr_i | input | ADDR_W | Read address |
| rd_word_i | input | 72 | Raw word from memory |
| flt_en_i | input | 1 | Global fault-injection enable |
| flt_mode_i | input | 3 | Injection mode; 4 flips one bit, 5 flips two |
| flt_addr_i | input | ADDR_W | Address that triggers injection |
| inj_pos0_i | input | 7 | First bit position to flip |
| inj_pos1_i | input | 7 | Second bit position, used in mode 5 |
| out_valid_o | output | 1 | Results valid |
| syndrome_o | output | 8 | Syndrome |
| stored_chk_o | output | 8 | Check bits of the word after injection |
| calc_chk_o | output | 8 | Check bits recomputed over the data half |
| sec_err_o | output | 1 | Single error located |
| ded_err_o | output | 1 | Uncorrectable error |
| bit_idx_o | output | 7 | Faulty bit, 0-63 data, 64-71 check |

## Verification
The hardest cases to reach are syndromes that match no column. These include even-weight double faults and a double fault that lands in both halves of the word. Clean random words only reach them through the injector. The stimulus therefore writes correct code words and then programs mode 5 at the read address with random position pairs. It also drives raw words with random check bytes, which produces odd-weight syndromes outside the column table. Directed reads cover the positions at the edges of each half, an out-of-range position, equal positions, and address, enable and mode mismatches.

// File: rtl/rdinj_pkg.sv
package rdinj_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int POS_W  = $clog2(WORD_W);
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_RD_ONE = 3'd4;
  localparam logic [MODE_W-1:0] MODE_RD_TWO = 3'd5;

  // odd-weight syndrome column of data bit i
  function automatic logic [CHK_W-1:0] col_of(input int i);
    case (i)
      0: return 8'h23;  1: return 8'h43;  2: return 8'h83;  3: return 8'h3D;
      4: return 8'h45;  5: return 8'h85;  6: return 8'h89;  7: return 8'h49;
      8: return 8'h46;  9: return 8'h86; 10: return 8'h07; 11: return 8'h7A;
     12: return 8'h8A; 13: return 8'h0B; 14: return 8'h13; 15: return 8'h92;
     16: return 8'h8C; 17: return 8'h0D; 18: return 8'h0E; 19: return 8'hF4;
     20: return 8'h15; 21: return 8'h16; 22: return 8'h26; 23: return 8'h25;
     24: return 8'h19; 25: return 8'h1A; 26: return 8'h1C; 27: return 8'hE9;
     28: return 8'h2A; 29: return 8'h2C; 30: return 8'h4C; 31: return 8'h4A;
     32: return 8'h32; 33: return 8'h34; 34: return 8'h38; 35: return 8'hD3;
     36: return 8'h54; 37: return 8'h58; 38: return 8'h98; 39: return 8'h94;
     40: return 8'h64; 41: return 8'h68; 42: return 8'h70; 43: return 8'hA7;
     44: return 8'hA8; 45: return 8'hB0; 46: return 8'h31; 47: return 8'h29;
     48: return 8'hC8; 49: return 8'hD0; 50: return 8'hE0; 51: return 8'h4F;
     52: return 8'h51; 53: return 8'h61; 54: return 8'h62; 55: return 8'h52;
     56: return 8'h91; 57: return 8'hA1; 58: return 8'hC1; 59: return 8'h9E;
     60: return 8'hA2; 61: return 8'hC2; 62: return 8'hC4; 63: return 8'hA4;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rdinj_flip.sv
module rdinj_flip
  import rdinj_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] flt_addr_i,
  input  logic [POS_W-1:0]  pos0_i,
  input  logic [POS_W-1:0]  pos1_i,
  output logic [WORD_W-1:0] word_o
);
  logic one_mode, two_mode, active;
  logic [WORD_W-1:0] mask;

  assign one_mode = (mode_i == MODE_RD_ONE);
  assign two_mode = (mode_i == MODE_RD_TWO);
  assign active   = en_i && (one_mode || two_mode) && (addr_i == flt_addr_i);

  // out-of-range positions match no bit, so they flip nothing
  for (genvar b = 0; b < WORD_W; b++) begin : g_mask
    assign mask[b] = (pos0_i == POS_W'(b)) || (two_mode && (pos1_i == POS_W'(b)));
  end

  assign word_o = active ? (word_i ^ mask) : word_i;
endmodule

// File: rtl/rdinj_enc.sv
module rdinj_enc
  import rdinj_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  always_comb begin
    logic [CHK_W-1:0] col;
    chk_o = '0;
    for (int i = 0; i < DATA_W; i++) begin
      col = col_of(i);
      if (data_i[i]) chk_o = chk_o ^ col;
    end
  end
endmodule

// File: rtl/rdinj_dec.sv
module rdinj_dec
  import rdinj_pkg::*;
(
  input  logic [CHK_W-1:0] syn_i,
  output logic             sec_o,
  output logic             ded_o,
  output logic [POS_W-1:0] idx_o
);
  logic [DATA_W-1:0] hit_d;
  logic [CHK_W-1:0]  hit_c;

  for (genvar i = 0; i < DATA_W; i++) begin : g_dcol
    assign hit_d[i] = (syn_i == col_of(i));
  end
  for (genvar k = 0; k < CHK_W; k++) begin : g_ccol
    assign hit_c[k] = (syn_i == CHK_W'(1 << k));
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < DATA_W; i++)
      if (hit_d[i]) idx_o = POS_W'(i);
    for (int k = 0; k < CHK_W; k++)
      if (hit_c[k]) idx_o = POS_W'(DATA_W + k);
  end

  assign sec_o = (|hit_d) || (|hit_c);
  assign ded_o = (syn_i != '0) && !sec_o;
endmodule

// File: rtl/rdinj_sec_ded_chk.sv
module rdinj_sec_ded_chk
  import rdinj_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [WORD_W-1:0] rd_word_i,
  input  logic              flt_en_i,
  input  logic [MODE_W-1:0] flt_mode_i,
  input  logic [ADDR_W-1:0] flt_addr_i,
  input  logic [POS_W-1:0]  inj_pos0_i,
  input  logic [POS_W-1:0]  inj_pos1_i,
  output logic              out_valid_o,
  output logic [CHK_W-1:0]  syndrome_o,
  output logic [CHK_W-1:0]  stored_chk_o,
  output logic [CHK_W-1:0]  calc_chk_o,
  output logic              sec_err_o,
  output logic              ded_err_o,
  output logic [POS_W-1:0]  bit_idx_o
);
  logic [WORD_W-1:0] word_x;
  logic [CHK_W-1:0]  chk_calc, syn;
  logic              sec, ded;
  logic [POS_W-1:0]  idx;

  rdinj_flip #(.ADDR_W(ADDR_W)) u_flip (
    .word_i(rd_word_i), .addr_i(rd_addr_i), .en_i(flt_en_i), .mode_i(flt_mode_i),
    .flt_addr_i(flt_addr_i), .pos0_i(inj_pos0_i), .pos1_i(inj_pos1_i), .word_o(word_x)
  );

  rdinj_enc u_enc (.data_i(word_x[DATA_W-1:0]), .chk_o(chk_calc));

  assign syn = word_x[WORD_W-1:DATA_W] ^ chk_calc;

  rdinj_dec u_dec (.syn_i(syn), .sec_o(sec), .ded_o(ded), .idx_o(idx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      syndrome_o   <= '0;
      stored_chk_o <= '0;
      calc_chk_o   <= '0;
      sec_err_o    <= 1'b0;
      ded_err_o    <= 1'b0;
      bit_idx_o    <= '0;
    end else begin
      out_valid_o  <= rd_valid_i;
      syndrome_o   <= syn;
      stored_chk_o <= word_x[WORD_W-1:DATA_W];
      calc_chk_o   <= chk_calc;
      sec_err_o    <= sec;
      ded_err_o    <= ded;
      bit_idx_o    <= idx;
    end
  end
endmodule

// File: rtl/rdinj_sec_ded_sva.sv
module rdinj_sec_ded_sva
  import rdinj_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_valid_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [WORD_W-1:0] rd_word_i,
  input logic              flt_en_i,
  input logic [MODE_W-1:0] flt_mode_i,
  input logic [ADDR_W-1:0] flt_addr_i,
  input logic [POS_W-1:0]  inj_pos0_i,
  input logic [POS_W-1:0]  inj_pos1_i,
  input logic              out_valid_o,
  input logic [CHK_W-1:0]  syndrome_o,
  input logic [CHK_W-1:0]  stored_chk_o,
  input logic [CHK_W-1:0]  calc_chk_o,
  input logic              sec_err_o,
  input logic              ded_err_o,
  input logic [POS_W-1:0]  bit_idx_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> out_valid_o);
  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !out_valid_o);
  a_r3_no_inject_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_en_i |=> stored_chk_o == $past(rd_word_i[WORD_W-1:DATA_W]));
  a_r5_clean_zero_syn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_err_o && !ded_err_o) |-> (syndrome_o == '0 && bit_idx_o == '0));
  a_r6_data_odd_weight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_err_o && bit_idx_o < POS_W'(DATA_W)) |-> (^syndrome_o) && ($countones(syndrome_o) > 2));
  a_r7_chk_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_err_o && bit_idx_o >= POS_W'(DATA_W)) |-> ($countones(syndrome_o) == 1 && bit_idx_o < POS_W'(WORD_W)));
  a_r8_excl_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_err_o && ded_err_o));
  a_r8_ded_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ded_err_o |-> (syndrome_o != '0 && bit_idx_o == '0));
endmodule

bind rdinj_sec_ded_chk rdinj_sec_ded_sva #(.ADDR_W(ADDR_W)) sva_i (.*);

// File: tb/rdinj_sec_ded_chk_tb_top.sv
module rdinj_sec_ded_chk_tb_top;
  localparam int AW = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [71:0] rd_word_i = '0;
  logic        flt_en_i = 1'b0;
  logic [2:0]  flt_mode_i = '0;
  logic [AW-1:0] flt_addr_i = '0;
  logic [6:0]  inj_pos0_i = '0;
  logic [6:0]  inj_pos1_i = '0;
  logic        out_valid_o;
  logic [7:0]  syndrome_o, stored_chk_o, calc_chk_o;
  logic        sec_err_o, ded_err_o;
  logic [6:0]  bit_idx_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  rdinj_sec_ded_chk #(.ADDR_W(AW)) dut_i (.*);

  localparam logic [7:0] COLS [64] = '{
    8'h23, 8'h43, 8'h83, 8'h3D, 8'h45, 8'h85, 8'h89, 8'h49,
    8'h46, 8'h86, 8'h07, 8'h7A, 8'h8A, 8'h0B, 8'h13, 8'h92,
    8'h8C, 8'h0D, 8'h0E, 8'hF4, 8'h15, 8'h16, 8'h26, 8'h25,
    8'h19, 8'h1A, 8'h1C, 8'hE9, 8'h2A, 8'h2C, 8'h4C, 8'h4A,
    8'h32, 8'h34, 8'h38, 8'hD3, 8'h54, 8'h58, 8'h98, 8'h94,
    8'h64, 8'h68, 8'h70, 8'hA7, 8'hA8, 8'hB0, 8'h31, 8'h29,
    8'hC8, 8'hD0, 8'hE0, 8'h4F, 8'h51, 8'h61, 8'h62, 8'h52,
    8'h91, 8'hA1, 8'hC1, 8'h9E, 8'hA2, 8'hC2, 8'hC4, 8'hA4};

  function automatic logic [7:0] m_enc(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= COLS[i];
    return c;
  endfunction

  function automatic logic [71:0] m_inj(input logic [71:0] w, input logic en, input logic [2:0] md,
                                        input logic amatch, input int p0, input int p1);
    logic [71:0] r = w;
    if (en && amatch && (md == 3'd4 || md == 3'd5)) begin
      if (p0 < 72) r[p0] = ~r[p0];
      if (md == 3'd5 && p1 < 72 && p1 != p0) r[p1] = ~r[p1];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive one read, sample one cycle later away from the edge
  task automatic rd(input logic [71:0] w, input logic en, input logic [2:0] md,
                    input logic [AW-1:0] a, input logic [AW-1:0] fa, input int p0, input int p1);
    logic [71:0] wx;
    logic [7:0]  sc, cc, sy, ix;
    logic        s, dd;
    string       ctag;
    rd_valid_i = 1'b1; rd_word_i = w; flt_en_i = en; flt_mode_i = md;
    rd_addr_i = a; flt_addr_i = fa; inj_pos0_i = 7'(p0); inj_pos1_i = 7'(p1);
    wx = m_inj(w, en, md, a == fa, p0, p1);
    sc = wx[71:64]; cc = m_enc(wx[63:0]); sy = sc ^ cc;
    s = 1'b0; ix = 8'd0; ctag = "R5";
    for (int i = 0; i < 64; i++) if (sy == COLS[i]) begin s = 1'b1; ix = 8'(i); ctag = "R6"; end
    for (int k = 0; k < 8; k++) if (sy == 8'(1 << k)) begin s = 1'b1; ix = 8'(64 + k); ctag = "R7"; end
    dd = (sy != 0) && !s;
    if (dd) ctag = "R8";
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    chk("R2 valid", {7'd0, out_valid_o}, 8'd1);
    chk("R1 stored/R3/R4", stored_chk_o, sc);
    chk("R1 calc", calc_chk_o, cc);
    chk("R5 syndrome", syndrome_o, sy);
    chk({ctag, " sec"}, {7'd0, sec_err_o}, {7'd0, s});
    chk({ctag, " ded"}, {7'd0, ded_err_o}, {7'd0, dd});
    chk({ctag, " idx"}, {1'b0, bit_idx_o}, ix);
  endtask

  function automatic logic [71:0] good(input logic [63:0] d);
    return {m_enc(d), d};
  endfunction

  initial begin
    logic [63:0] d;
    void'($urandom(32'h5EED_0042));
    #12;
    chk("R2 reset valid", {7'd0, out_valid_o}, 8'd0);
    chk("R2 reset syn", syndrome_o, 8'd0);
    chk("R2 reset idx", {1'b0, bit_idx_o}, 8'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 idle valid", {7'd0, out_valid_o}, 8'd0);

    d = 64'h0123_4567_89AB_CDEF;
    rd(good(d), 1'b0, 3'd0, 16'h10, 16'h10, 0, 0);      // R5 clean
    rd(good(d), 1'b1, 3'd4, 16'h10, 16'h10, 0, 0);      // R6 D0
    rd(good(d), 1'b1, 3'd4, 16'h10, 16'h10, 63, 0);     // R6 D63
    rd(good(d), 1'b1, 3'd4, 16'h10, 16'h10, 19, 0);     // R6 D19
    rd(good(d), 1'b1, 3'd4, 16'h10, 16'h10, 64, 0);     // R7 chk0
    rd(good(d), 1'b1, 3'd4, 16'h10, 16'h10, 71, 0);     // R7 chk7
    rd(good(d), 1'b1, 3'd5, 16'h10, 16'h10, 3, 35);     // R8 two data bits
    rd(good(d), 1'b1, 3'd5, 16'h10, 16'h10, 10, 68);    // R8 data + check
    rd(good(d), 1'b1, 3'd5, 16'h10, 16'h10, 59, 59);    // R4 equal positions
    rd(good(d), 1'b1, 3'd4, 16'h10, 16'h10, 100, 5);    // R4 out of range
    rd(good(d), 1'b1, 3'd4, 16'h10, 16'h10, 1, 2);      // R4 pos1 unused in mode 4
    rd(good(d), 1'b1, 3'd4, 16'h11, 16'h10, 1, 0);      // R3 addr mismatch
    rd(good(d), 1'b0, 3'd5, 16'h10, 16'h10, 1, 2);      // R3 disabled
    for (int m = 0; m < 8; m++)
      if (m != 4 && m != 5) rd(good(d), 1'b1, 3'(m), 16'h10, 16'h10, 7, 8); // R3 other modes
    for (int n = 0; n < 400; n++) begin
      logic [71:0] w;
      d = {$urandom, $urandom};
      w = good(d);
      if (n % 4 == 3) w[71:64] = 8'($urandom);          // R8/R6 odd raw syndromes
      rd(w, 1'($urandom), 3'($urandom_range(3, 6)), 16'($urandom_range(0, 3)),
         16'($urandom_range(0, 3)), int'($urandom_range(0, 80)), int'($urandom_range(0, 80)));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule